// File: doc/BRIEF.md
# PPS-Disciplined Seconds/Ticks Time Keeper

This block keeps a running timestamp made of a seconds count and a sub-second ticks count. The ticks count advances on every clock and rolls over at a programmable ticks-per-second value, and each rollover adds one to the seconds count. Software sets the time through a write strobe with a small address. It stages new seconds and ticks values and then commits them with a single write. The commit either takes effect at once or waits for the next pulse-per-second (PPS) edge. That edge is taken from one of two pulse inputs with a chosen polarity.

The pulse inputs are asynchronous. Each one passes through a synchroniser before edge detection. On every selected PPS edge the block records the time it held just before that edge. This gives software a second readback pair that relates the free-running count to the external pulse. The live time is also presented as registered outputs.

Top module: `pps_timekeeper`

## Requirements
- R1: While reset is high and in the first cycle after it, the live and snapshot outputs read zero. Reset sets ticks-per-second to the default 100,000,000, selects falling-edge polarity on the connector input (flags = 0), and leaves no load armed.
- R2: Absent a load, the ticks output rises by one per clock. In the cycle after ticks equals ticks-per-second minus one (or more), ticks reads 0 and seconds has risen by one.
- R3: Writes to address 0 (seconds) and address 1 (ticks) only stage values. The live outputs are unaffected until a commit.
- R4: A write to address 3 with data bit 0 = 1 loads the staged pair. In the cycle after that write is taken, the live outputs show the staged values, and counting continues from there.
- R5: A write to address 3 with data bit 0 = 0 arms a load. The staged pair is loaded on the next selected PPS edge, and the arming then clears, so later edges do not reload.
- R6: Flags (address 2) bit 0 selects the PPS polarity: 0 acts on falling edges, 1 acts on rising edges. Edges of the other polarity are ignored.
- R7: Flags bit 1 selects the PPS source: 0 is the connector input `pps_ext`, 1 is the link input `pps_link`. The other input is ignored.
- R8: A PPS transition is acted on at the third rising clock edge that samples the new level. The first two samples feed a two-stage synchroniser.
- R9: On each selected PPS edge, the snapshot outputs capture the live time held just before that edge. This holds also when an armed load happens on the same edge.
- R10: A write to address 4 sets ticks-per-second. Rollovers from then on use the new value.
- R11: An immediate commit taken on the same clock as an armed PPS load wins, and it clears the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 seconds, 1 ticks, 2 flags, 3 commit, 4 ticks-per-second) |
| wr_data | input | 32 | Write data |
| pps_ext | input | 1 | Asynchronous connector pulse input |
| pps_link | input | 1 | Asynchronous link pulse input |
| live_secs | output | 32 | Current seconds |
| live_ticks | output | 32 | Current ticks |
| pps_secs | output | 32 | Seconds captured at the last selected PPS edge |
| pps_ticks | output | 32 | Ticks captured at the last selected PPS edge |

## Verification
Counter faults show up on the live outputs within one clock, as a skipped tick, a missed rollover or a seconds value that fails to move. Arming and edge-selection faults are quieter. A stuck arm flag stays invisible until the next selected PPS edge, where it reloads a stale staged time. A wrong polarity or source choice shows up only as a snapshot that fails to move, or moves on the wrong pulse. The stimulus therefore restages the time between PPS pulses, so that any spurious load produces a visibly different value. A reference model checks all four outputs on every clock.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int TK_AW = 3;

  typedef enum logic [TK_AW-1:0] {
    TK_STAGE_SECS  = 3'd0,
    TK_STAGE_TICKS = 3'd1,
    TK_PPS_CFG     = 3'd2,
    TK_COMMIT      = 3'd3,
    TK_RATE        = 3'd4
  } tk_reg_e;

  localparam int TK_CFG_RISE_BIT = 0;
  localparam int TK_CFG_SRC_BIT  = 1;
  localparam int TK_COMMIT_NOW_BIT = 0;
endpackage

// File: rtl/tk_sync.sv
module tk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/tk_pps_front.sv
module tk_pps_front #(
  parameter int SYNC_STAGES = 2,
  parameter int N_SRC       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pps_raw,
  input  logic             src_sel,
  input  logic             rise_sel,
  output logic             pps_evt
);
  logic [N_SRC-1:0] pps_sync;
  logic             sel_lvl;
  logic             prev_q;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_sync
    tk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pps_raw[gi]),
      .q   (pps_sync[gi])
    );
  end

  assign sel_lvl = src_sel ? pps_sync[1] : pps_sync[0];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_lvl;
  end

  assign pps_evt = rise_sel ? (sel_lvl & ~prev_q) : (~sel_lvl & prev_q);

  // R8
  evt_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pps_evt |=> !pps_evt);
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int SECS_W = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SECS_W-1:0] ld_secs,
  input  logic [TICK_W-1:0] ld_ticks,
  input  logic [TICK_W-1:0] tps,
  output logic [SECS_W-1:0] secs_q,
  output logic [TICK_W-1:0] ticks_q
);
  logic [TICK_W-1:0] last_tick;
  logic              wrap;

  assign last_tick = tps - TICK_W'(1);
  assign wrap      = (ticks_q >= last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else if (load) begin
      secs_q  <= ld_secs;
      ticks_q <= ld_ticks;
    end else if (wrap) begin
      secs_q  <= secs_q + SECS_W'(1);
      ticks_q <= '0;
    end else begin
      ticks_q <= ticks_q + TICK_W'(1);
    end
  end

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && ticks_q < last_tick) |=>
      (ticks_q == $past(ticks_q) + TICK_W'(1) && secs_q == $past(secs_q)));
  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && ticks_q >= last_tick) |=>
      (ticks_q == '0 && secs_q == $past(secs_q) + SECS_W'(1)));
  // R4
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (secs_q == $past(ld_secs) && ticks_q == $past(ld_ticks)));
endmodule

// File: rtl/tk_snapshot.sv
module tk_snapshot #(
  parameter int SECS_W = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [SECS_W-1:0] secs_in,
  input  logic [TICK_W-1:0] ticks_in,
  output logic [SECS_W-1:0] snap_secs,
  output logic [TICK_W-1:0] snap_ticks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_secs  <= '0;
      snap_ticks <= '0;
    end else if (capture) begin
      snap_secs  <= secs_in;
      snap_ticks <= ticks_in;
    end
  end

  // R9
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (snap_secs == $past(secs_in) && snap_ticks == $past(ticks_in)));
  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(snap_secs) && $stable(snap_ticks)));
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
  parameter int SECS_W      = 32,
  parameter int TICK_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DEFAULT_TPS = 100_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_stb,
  input  logic [tk_pkg::TK_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    pps_ext,
  input  logic                    pps_link,
  output logic [SECS_W-1:0]       live_secs,
  output logic [TICK_W-1:0]       live_ticks,
  output logic [SECS_W-1:0]       pps_secs,
  output logic [TICK_W-1:0]       pps_ticks
);
  import tk_pkg::*;

  localparam logic [TICK_W-1:0] TPS_RST = TICK_W'(DEFAULT_TPS);

  logic [SECS_W-1:0] stage_secs_q;
  logic [TICK_W-1:0] stage_ticks_q;
  logic [TICK_W-1:0] tps_q;
  logic              cfg_rise_q;
  logic              cfg_src_q;
  logic              armed_q;

  logic wr_commit, commit_now, commit_arm;
  logic pps_evt, load;

  assign wr_commit  = wr_stb && (wr_addr == TK_COMMIT);
  assign commit_now = wr_commit &&  wr_data[TK_COMMIT_NOW_BIT];
  assign commit_arm = wr_commit && !wr_data[TK_COMMIT_NOW_BIT];
  assign load       = commit_now || (pps_evt && armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_secs_q  <= '0;
      stage_ticks_q <= '0;
      tps_q         <= TPS_RST;
      cfg_rise_q    <= 1'b0;
      cfg_src_q     <= 1'b0;
    end else if (wr_stb) begin
      case (wr_addr)
        TK_STAGE_SECS:  stage_secs_q  <= SECS_W'(wr_data);
        TK_STAGE_TICKS: stage_ticks_q <= TICK_W'(wr_data);
        TK_PPS_CFG: begin
          cfg_rise_q <= wr_data[TK_CFG_RISE_BIT];
          cfg_src_q  <= wr_data[TK_CFG_SRC_BIT];
        end
        TK_RATE:        tps_q <= TICK_W'(wr_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      armed_q <= 1'b0;
    else if (commit_now)          armed_q <= 1'b0;
    else if (commit_arm)          armed_q <= 1'b1;
    else if (pps_evt && armed_q)  armed_q <= 1'b0;
  end

  tk_pps_front #(.SYNC_STAGES(SYNC_STAGES), .N_SRC(2)) u_front (
    .clk      (clk),
    .rst      (rst),
    .pps_raw  ({pps_link, pps_ext}),
    .src_sel  (cfg_src_q),
    .rise_sel (cfg_rise_q),
    .pps_evt  (pps_evt)
  );

  tk_counter #(.SECS_W(SECS_W), .TICK_W(TICK_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ld_secs  (stage_secs_q),
    .ld_ticks (stage_ticks_q),
    .tps      (tps_q),
    .secs_q   (live_secs),
    .ticks_q  (live_ticks)
  );

  tk_snapshot #(.SECS_W(SECS_W), .TICK_W(TICK_W)) u_snap (
    .clk        (clk),
    .rst        (rst),
    .capture    (pps_evt),
    .secs_in    (live_secs),
    .ticks_in   (live_ticks),
    .snap_secs  (pps_secs),
    .snap_ticks (pps_ticks)
  );

  // R5
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pps_evt && armed_q && !wr_commit) |=> !armed_q);
  // R11
  now_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    commit_now |=> !armed_q);
  // R3
  stage_no_touch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && (wr_addr == TK_STAGE_SECS) && !load) |=> (live_secs != $past(wr_data[SECS_W-1:0]) || live_secs == $past(live_secs) + SECS_W'(1) || live_secs == $past(live_secs)));
endmodule

// File: tb/tb_pps_timekeeper.sv
module tb_pps_timekeeper;
  localparam int unsigned DEF_TPS = 100_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pps_ext = 1'b0;
  logic        pps_link = 1'b0;
  logic [31:0] live_secs, live_ticks, pps_secs, pps_ticks;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  pps_timekeeper dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .pps_ext(pps_ext), .pps_link(pps_link),
    .live_secs(live_secs), .live_ticks(live_ticks),
    .pps_secs(pps_secs), .pps_ticks(pps_ticks)
  );

  // behavioural reference model
  bit [31:0] m_secs = 0, m_ticks = 0, m_ss = 0, m_st = 0, m_tps = DEF_TPS;
  bit [31:0] m_snap_s = 0, m_snap_t = 0, n_s, n_t;
  bit m_rise = 0, m_src = 0, m_armed = 0;
  bit ex1 = 0, ex2 = 0, lk1 = 0, lk2 = 0, prv = 0, sel, evt, imm, arm;

  always @(posedge clk) begin
    if (rst) begin
      m_secs = 0; m_ticks = 0; m_ss = 0; m_st = 0; m_tps = DEF_TPS;
      m_snap_s = 0; m_snap_t = 0; m_rise = 0; m_src = 0; m_armed = 0;
      ex1 = 0; ex2 = 0; lk1 = 0; lk2 = 0; prv = 0;
    end else begin
      sel = m_src ? lk2 : ex2;
      evt = m_rise ? (sel && !prv) : (!sel && prv);
      imm = wr_stb && wr_addr == 3 && wr_data[0];
      arm = wr_stb && wr_addr == 3 && !wr_data[0];
      if (imm || (evt && m_armed)) begin n_s = m_ss; n_t = m_st; end
      else if (m_ticks >= m_tps - 1) begin n_s = m_secs + 1; n_t = 0; end
      else begin n_s = m_secs; n_t = m_ticks + 1; end
      if (evt) begin m_snap_s = m_secs; m_snap_t = m_ticks; end
      if (imm) m_armed = 0;
      else if (arm) m_armed = 1;
      else if (evt) m_armed = 0;
      if (wr_stb) begin
        if (wr_addr == 0) m_ss = wr_data;
        if (wr_addr == 1) m_st = wr_data;
        if (wr_addr == 2) begin m_rise = wr_data[0]; m_src = wr_data[1]; end
        if (wr_addr == 4) m_tps = wr_data;
      end
      prv = sel; ex2 = ex1; ex1 = pps_ext; lk2 = lk1; lk1 = pps_link;
      m_secs = n_s; m_ticks = n_t;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R2 model live secs", live_secs, m_secs);
      chk("R2 model live ticks", live_ticks, m_ticks);
      chk("R9 model snapshot secs", pps_secs, m_snap_s);
      chk("R9 model snapshot ticks", pps_ticks, m_snap_t);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] s0, t0, s1;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 reset live secs", live_secs, 0);
    chk("R1 reset live ticks", live_ticks, 0);
    chk("R1 reset snap secs", pps_secs, 0);
    chk("R1 reset snap ticks", pps_ticks, 0);
    cmp_on = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle secs", live_secs, 0);
    idle(20);
    chk("R1 default rate no wrap", live_secs, 0);
    chk("R2 ticks per clock", live_ticks, 21);

    // R10 new rate
    wr(3'd4, 32'd5);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (live_ticks == 4) seen = 1;
    end
    s0 = live_secs;
    @(negedge clk);
    chk("R10 wrap ticks", live_ticks, 0);
    chk("R10 wrap secs", live_secs, s0 + 1);

    // R3 staging does not touch live time
    wr(3'd0, 32'd100);
    wr(3'd1, 32'd2);
    chk("R3 staged secs not live", (live_secs == 100) ? 1 : 0, 0);
    // R4 immediate commit
    wr(3'd3, 32'd1);
    chk("R4 immediate secs", live_secs, 100);
    chk("R4 immediate ticks", live_ticks, 2);

    // R5 / R8 armed load on falling connector edge (R6 polarity 0)
    wr(3'd0, 32'd500);
    wr(3'd1, 32'd1);
    wr(3'd3, 32'd0);
    @(negedge clk); pps_ext = 1'b1;
    idle(6);
    chk("R6 rising ignored when falling selected", pps_secs, 0);
    pps_ext = 1'b0;
    idle(2);
    chk("R8 not loaded before third edge", (live_secs == 500) ? 1 : 0, 0);
    s0 = live_secs; t0 = live_ticks;
    @(negedge clk);
    chk("R5 armed load secs", live_secs, 500);
    chk("R5 armed load ticks", live_ticks, 1);
    chk("R9 snapshot pre-load secs", pps_secs, s0);
    chk("R9 snapshot pre-load ticks", pps_ticks, t0);
    idle(15);
    @(negedge clk); pps_ext = 1'b1;
    idle(5); pps_ext = 1'b0;
    idle(5);
    chk("R5 disarmed after load", (live_secs > 500) ? 1 : 0, 1);

    // R6 rising polarity
    wr(3'd2, 32'd1);
    @(negedge clk); pps_ext = 1'b1;
    idle(2);
    s0 = live_secs; t0 = live_ticks;
    @(negedge clk);
    chk("R6 rising capture secs", pps_secs, s0);
    chk("R6 rising capture ticks", pps_ticks, t0);
    idle(4); pps_ext = 1'b0;

    // R7 link source, connector ignored
    wr(3'd2, 32'd3);
    idle(4);
    s1 = pps_ticks;
    pps_ext = 1'b1; idle(5); pps_ext = 1'b0; idle(5);
    chk("R7 connector ignored", pps_ticks, s1);
    @(negedge clk); pps_link = 1'b1;
    idle(2);
    s0 = live_secs; t0 = live_ticks;
    @(negedge clk);
    chk("R7 link capture ticks", pps_ticks, t0);
    chk("R7 link capture secs", pps_secs, s0);
    idle(4); pps_link = 1'b0; idle(5);

    // R11 immediate commit coinciding with armed edge
    wr(3'd0, 32'd700);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd900);
    wr(3'd1, 32'd3);
    @(negedge clk); pps_link = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_stb = 1'b1; wr_addr = 3'd3; wr_data = 32'd1;
    @(negedge clk); wr_stb = 1'b0;
    chk("R11 coincident load secs", live_secs, 900);
    chk("R11 coincident load ticks", live_ticks, 3);
    wr(3'd0, 32'd1234);
    idle(3); pps_link = 1'b0; idle(4); pps_link = 1'b1; idle(5);
    chk("R11 arming cleared", (live_secs == 1234) ? 1 : 0, 0);

    idle(10);
    finish_up();
  end
endmodule